// File: doc/BRIEF.md
# Power Management Event Unit with Interval Timer

This block holds the event status, event enable and control registers of a power-management unit, together with a free-running interval timer, behind a 64-byte register window. Software reads and writes the window by offset. The unit drives a level-sensitive system control interrupt (SCI) from the enabled events. Writing a suspend request with the soft-off type produces a one-cycle shutdown request.

A separate two-byte advanced power management (APM) port sits beside the window. Writing its command byte is recorded. Two command values switch SCI mode on or off, and when the system allows it, each command write raises a one-cycle system management interrupt (SMI) request. The timer advances on a tick-enable input running at the timer rate, so the block needs no clock of its own for the timer. The timer width is a parameter, 24 bits by default.

Top module: `pmu_event_unit`

## Requirements
- R1: The timer resets to 0, advances by one on each clock with `tick_en` high, and wraps modulo 2^TMR_W. A read of window offset 0x08 returns its TMR_W bits zero-extended to 32 bits.
- R2: The window offset is `reg_addr[5:0]`. Offset 0x00 is status, 0x02 is enable and 0x04 is control. The enable register stores all 16 written bits. Every other offset reads as 0.
- R3: A write to status clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: Status bit 0 (timer overflow) is set by the tick that moves the timer onto a multiple of 2^(TMR_W-1), including the wrap to 0. A same-cycle clear loses to this event.
- R5: `sci` is high when status AND enable is nonzero in bit 10, 8, 5 or 0. It follows the registers one clock later.
- R6: Control bit 13 (suspend request) is never stored and reads as 0. A control write with bit 13 set and bits 12:10 equal to 0 drives `soft_off_req` high for exactly the one cycle after the write. Other types give no request.
- R7: A `pwr_btn` pulse sets status bit 8 only while enable bit 8 is 1.
- R8: An APM command write (`apm_sel`=0) stores the byte, readable on `apm_rdata` with `apm_sel`=0. Value 0xF1 sets control bit 0 and 0xF0 clears it. Other values leave control unchanged.
- R9: Each APM command write drives `smi_req` high for the one cycle after it while `smi_allow` is 1. The APM status byte (`apm_sel`=1) is plain read/write storage and raises no SMI.
- R10: After reset, status, enable, control and both APM bytes are 0, and `sci`, `soft_off_req` and `smi_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer advance enable, one pulse per timer period |
| reg_addr | input | AW | Window address; only bits 5:0 decode |
| reg_wr | input | 1 | Window write strobe |
| reg_wdata | input | 16 | Window write data |
| reg_rdata | output | 32 | Window read data for `reg_addr` (combinational) |
| pwr_btn | input | 1 | Power-button event pulse |
| apm_wr | input | 1 | APM port write strobe |
| apm_sel | input | 1 | APM byte select: 0 command, 1 status |
| apm_wdata | input | 8 | APM write data |
| apm_rdata | output | 8 | APM byte selected by `apm_sel` |
| smi_allow | input | 1 | Permits SMI requests on command writes |
| sci | output | 1 | System control interrupt level |
| soft_off_req | output | 1 | One-cycle soft power-off request |
| smi_req | output | 1 | One-cycle SMI request |

## Verification
Register reads are combinational, so a value written at one edge is sampled half a cycle after that edge. Status set by a tick or button pulse is sampled the same way. `soft_off_req` and `smi_req` are registered from the write, so the bench samples them high in the half cycle after the write edge and low one cycle later. `sci` lags the status and enable registers by one further edge, so the bench first samples it still at its old value right after the causing edge and then at the new value one cycle later. The bench shrinks the timer to 10 bits so that both overflow boundaries, including the wrap, are reached.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   localparam int REG_W   = 16;
   localparam int WIN_AW  = 6;
   localparam logic [WIN_AW-1:0] OFS_STS = 6'h00;
   localparam logic [WIN_AW-1:0] OFS_EN  = 6'h02;
   localparam logic [WIN_AW-1:0] OFS_CTL = 6'h04;
   localparam logic [WIN_AW-1:0] OFS_TMR = 6'h08;
   localparam int BIT_TMR   = 0;
   localparam int BIT_GBL   = 5;
   localparam int BIT_PWR   = 8;
   localparam int BIT_RTC   = 10;
   localparam int BIT_SUSP  = 13;
   localparam int SUSP_LSB  = 10;
   localparam int SUSP_W    = 3;
   localparam int SCI_ENBIT = 0;
   localparam logic [REG_W-1:0] SCI_SRC_MASK =
      REG_W'((1 << BIT_RTC) | (1 << BIT_PWR) | (1 << BIT_GBL) | (1 << BIT_TMR));
   localparam logic [7:0] APM_SCI_ON  = 8'hF1;
   localparam logic [7:0] APM_SCI_OFF = 8'hF0;
endpackage

// File: rtl/pmu_timer.sv
module pmu_timer #(
   parameter int TMR_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   output logic [TMR_W-1:0] count,
   output logic             ovf_evt
);
   localparam int HALF_MSB = TMR_W - 2;

   generate
      if (TMR_W < 2 || TMR_W > 32) begin : g_bad_width
         $error("pmu_timer: TMR_W must lie in 2..32");
      end
   endgenerate

   // the next tick lands on a multiple of 2^(TMR_W-1) when all lower bits are ones
   assign ovf_evt = tick_en && (&count[HALF_MSB:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count <= '0;
      else if (tick_en) count <= count + TMR_W'(1);
   end

   assert_tick_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> count == $past(count) + TMR_W'(1));
   assert_tick_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(count));
endmodule

// File: rtl/pmu_evt_regs.sv
module pmu_evt_regs
   import pmu_pkg::*;
#(
   parameter logic [REG_W-1:0] SCI_MASK       = SCI_SRC_MASK,
   parameter bit               SCI_REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sts_wr,
   input  logic             en_wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             ovf_evt,
   input  logic             pwr_btn,
   output logic [REG_W-1:0] sts,
   output logic [REG_W-1:0] en,
   output logic             sci
);
   logic [REG_W-1:0] set_vec;
   logic             sci_raw;

   always_comb begin
      set_vec          = '0;
      set_vec[BIT_TMR] = ovf_evt;
      set_vec[BIT_PWR] = pwr_btn && en[BIT_PWR];
   end

   for (genvar i = 0; i < REG_W; i++) begin : g_sts_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  sts[i] <= 1'b0;
         else if (set_vec[i])         sts[i] <= 1'b1;
         else if (sts_wr && wdata[i]) sts[i] <= 1'b0;
      end

      assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (sts_wr && wdata[i] && !set_vec[i]) |=> !sts[i]);
      assert_w0_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (sts_wr && !wdata[i] && !set_vec[i]) |=> sts[i] == $past(sts[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en <= '0;
      else if (en_wr) en <= wdata;
   end

   assign sci_raw = |(sts & en & SCI_MASK);

   generate
      if (SCI_REGISTERED) begin : g_sci_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sci <= 1'b0;
            else        sci <= sci_raw;
         end
      end else begin : g_sci_comb
         assign sci = sci_raw;
      end
   endgenerate

   assert_ovf_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> sts[BIT_TMR]);
   assert_pwr_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[BIT_PWR]) |-> $past(pwr_btn && en[BIT_PWR]));
endmodule

// File: rtl/pmu_ctl_apm.sv
module pmu_ctl_apm
   import pmu_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             apm_wr,
   input  logic             apm_sel,
   input  logic [7:0]       apm_wdata,
   input  logic             smi_allow,
   output logic [REG_W-1:0] ctl,
   output logic [7:0]       apm_cmd,
   output logic [7:0]       apm_sts,
   output logic             soft_off_req,
   output logic             smi_req
);
   logic             cmd_wr;
   logic             susp_off;
   logic [REG_W-1:0] ctl_next;

   assign cmd_wr   = apm_wr && !apm_sel;
   assign susp_off = ctl_wr && wdata[BIT_SUSP] &&
                     (wdata[SUSP_LSB +: SUSP_W] == '0);

   always_comb begin
      ctl_next = ctl;
      if (ctl_wr) begin
         ctl_next           = wdata;
         ctl_next[BIT_SUSP] = 1'b0;
      end
      if (cmd_wr && apm_wdata == APM_SCI_ON)  ctl_next[SCI_ENBIT] = 1'b1;
      if (cmd_wr && apm_wdata == APM_SCI_OFF) ctl_next[SCI_ENBIT] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl          <= '0;
         apm_cmd      <= '0;
         apm_sts      <= '0;
         soft_off_req <= 1'b0;
         smi_req      <= 1'b0;
      end else begin
         ctl          <= ctl_next;
         soft_off_req <= susp_off;
         smi_req      <= cmd_wr && smi_allow;
         if (cmd_wr)             apm_cmd <= apm_wdata;
         if (apm_wr && apm_sel)  apm_sts <= apm_wdata;
      end
   end

   assert_softoff_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      soft_off_req |-> $past(ctl_wr && wdata[BIT_SUSP] && wdata[SUSP_LSB +: SUSP_W] == '0));
   assert_softoff_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      soft_off_req |=> !soft_off_req || $past(ctl_wr));
   assert_smi_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      smi_req |-> $past(apm_wr && !apm_sel && smi_allow));
   assert_apm_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (apm_wr && !apm_sel && apm_wdata == APM_SCI_ON) |=> ctl[SCI_ENBIT]);
   assert_apm_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (apm_wr && !apm_sel && apm_wdata == APM_SCI_OFF) |=> !ctl[SCI_ENBIT]);
endmodule

// File: rtl/pmu_event_unit.sv
module pmu_event_unit
   import pmu_pkg::*;
#(
   parameter int AW             = 16,
   parameter int TMR_W          = 24,
   parameter bit SCI_REGISTERED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_en,
   input  logic [AW-1:0] reg_addr,
   input  logic          reg_wr,
   input  logic [15:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic          pwr_btn,
   input  logic          apm_wr,
   input  logic          apm_sel,
   input  logic [7:0]    apm_wdata,
   output logic [7:0]    apm_rdata,
   input  logic          smi_allow,
   output logic          sci,
   output logic          soft_off_req,
   output logic          smi_req
);
   generate
      if (AW < WIN_AW) begin : g_bad_aw
         $error("pmu_event_unit: AW must be at least 6");
      end
      if (TMR_W > 32) begin : g_bad_tmr
         $error("pmu_event_unit: TMR_W must fit the 32-bit read port");
      end
   endgenerate

   logic [WIN_AW-1:0] ofs;
   logic [TMR_W-1:0]  tmr_count;
   logic              ovf_evt;
   logic [REG_W-1:0]  sts, en, ctl;
   logic [7:0]        apm_cmd, apm_sts;
   logic              sts_wr, en_wr, ctl_wr;

   assign ofs    = reg_addr[WIN_AW-1:0];
   assign sts_wr = reg_wr && (ofs == OFS_STS);
   assign en_wr  = reg_wr && (ofs == OFS_EN);
   assign ctl_wr = reg_wr && (ofs == OFS_CTL);

   generate
      if (AW > WIN_AW) begin : g_hi_addr
         logic unused_addr_hi;
         assign unused_addr_hi = ^reg_addr[AW-1:WIN_AW];
      end
   endgenerate

   pmu_timer #(.TMR_W(TMR_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .count   (tmr_count),
      .ovf_evt (ovf_evt)
   );

   pmu_evt_regs #(
      .SCI_MASK       (SCI_SRC_MASK),
      .SCI_REGISTERED (SCI_REGISTERED)
   ) u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .sts_wr  (sts_wr),
      .en_wr   (en_wr),
      .wdata   (reg_wdata),
      .ovf_evt (ovf_evt),
      .pwr_btn (pwr_btn),
      .sts     (sts),
      .en      (en),
      .sci     (sci)
   );

   pmu_ctl_apm u_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctl_wr       (ctl_wr),
      .wdata        (reg_wdata),
      .apm_wr       (apm_wr),
      .apm_sel      (apm_sel),
      .apm_wdata    (apm_wdata),
      .smi_allow    (smi_allow),
      .ctl          (ctl),
      .apm_cmd      (apm_cmd),
      .apm_sts      (apm_sts),
      .soft_off_req (soft_off_req),
      .smi_req      (smi_req)
   );

   always_comb begin
      reg_rdata = '0;
      case (ofs)
         OFS_STS: reg_rdata[REG_W-1:0] = sts;
         OFS_EN:  reg_rdata[REG_W-1:0] = en;
         OFS_CTL: reg_rdata[REG_W-1:0] = ctl;
         OFS_TMR: reg_rdata[TMR_W-1:0] = tmr_count;
         default: reg_rdata = '0;
      endcase
   end

   assign apm_rdata = apm_sel ? apm_sts : apm_cmd;

   assert_susp_unstored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && ofs == OFS_CTL && !(apm_wr && !apm_sel)) |=>
         ctl == (($past(reg_wdata)) & ~(16'h1 << BIT_SUSP)));
   assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ofs != OFS_STS && ofs != OFS_EN && ofs != OFS_CTL && ofs != OFS_TMR) |-> reg_rdata == '0);
endmodule

// File: tb/pmu_event_unit_tb_top.sv
module pmu_event_unit_tb_top;
   localparam int TW = 10;
   localparam int NV = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic [15:0] reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        pwr_btn = 1'b0;
   logic        apm_wr = 1'b0;
   logic        apm_sel = 1'b0;
   logic [7:0]  apm_wdata = '0;
   logic [7:0]  apm_rdata;
   logic        smi_allow = 1'b0;
   logic        sci, soft_off_req, smi_req;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pmu_event_unit #(.AW(16), .TMR_W(TW)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .pwr_btn(pwr_btn),
      .apm_wr(apm_wr), .apm_sel(apm_sel), .apm_wdata(apm_wdata),
      .apm_rdata(apm_rdata), .smi_allow(smi_allow),
      .sci(sci), .soft_off_req(soft_off_req), .smi_req(smi_req)
   );

   // {is_read, offset[7:0], wdata[15:0], expected[31:0]}
   localparam logic [56:0] VEC [NV] = '{
      {1'b0, 8'h02, 16'h0100, 32'h0},           // R2 enable write
      {1'b1, 8'h02, 16'h0000, 32'h0000_0100},   // R2 enable read
      {1'b0, 8'h04, 16'h1C06, 32'h0},           // R2 control write
      {1'b1, 8'h04, 16'h0000, 32'h0000_1C06},   // R2 control read
      {1'b0, 8'h04, 16'h2406, 32'h0},           // R6 suspend type 1
      {1'b1, 8'h04, 16'h0000, 32'h0000_0406},   // R6 bit 13 not kept
      {1'b1, 8'h06, 16'h0000, 32'h0},           // R2 unmapped
      {1'b1, 8'h3E, 16'h0000, 32'h0},           // R2 unmapped
      {1'b1, 8'h42, 16'h0000, 32'h0000_0100},   // R2 offset masked to 6 bits
      {1'b1, 8'h01, 16'h0000, 32'h0}            // R2 odd offset
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] ofs, input logic [15:0] d);
      @(negedge clk);
      reg_addr = {8'hB0, ofs}; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] ofs, output logic [31:0] d);
      reg_addr = {8'hC0, ofs};
      #1 d = reg_rdata;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic apm(input logic sel, input logic [7:0] d);
      @(negedge clk);
      apm_sel = sel; apm_wdata = d; apm_wr = 1'b1;
      @(negedge clk);
      apm_wr = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      logic        seen_off;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state, R1 timer at 0
      rd(8'h00, v); check("R10 status", v, 0);
      rd(8'h02, v); check("R10 enable", v, 0);
      rd(8'h04, v); check("R10 control", v, 0);
      rd(8'h08, v); check("R1 timer reset", v, 0);
      apm_sel = 1'b0; #1 check("R10 apm cmd", {24'h0, apm_rdata}, 0);
      apm_sel = 1'b1; #1 check("R10 apm sts", {24'h0, apm_rdata}, 0);
      check("R10 outputs", {29'h0, sci, soft_off_req, smi_req}, 0);

      // table walk
      seen_off = 1'b0;
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][56]) begin
            rd(VEC[i][55:48], v);
            check($sformatf("R2 vector %0d", i), v, VEC[i][31:0]);
         end else begin
            wr(VEC[i][55:48], VEC[i][47:32]);
            if (soft_off_req) seen_off = 1'b1;
         end
      end
      check("R6 no soft-off for type 1", {31'h0, seen_off}, 0);

      wr(8'h04, 16'h0000);
      wr(8'h02, 16'h0001);

      // R1 counting
      ticks(5);
      rd(8'h08, v); check("R1 timer five ticks", v, 5);
      ticks(506);
      rd(8'h00, v); check("R4 no flag at 511", v, 0);
      ticks(1);
      rd(8'h08, v); check("R1 timer 512", v, 512);
      rd(8'h00, v); check("R4 flag at half boundary", v, 1);
      check("R5 sci lags one clock", {31'h0, sci}, 0);
      @(negedge clk);
      check("R5 sci high", {31'h0, sci}, 1);

      wr(8'h00, 16'hFFFE);
      rd(8'h00, v); check("R3 zero bits keep flag", v, 1);
      wr(8'h00, 16'h0001);
      rd(8'h00, v); check("R3 one bit clears flag", v, 0);
      check("R5 sci before drop", {31'h0, sci}, 1);
      @(negedge clk);
      check("R5 sci low", {31'h0, sci}, 0);

      ticks(511);
      rd(8'h00, v); check("R4 no flag at 1023", v, 0);
      ticks(1);
      rd(8'h08, v); check("R1 timer wraps", v, 0);
      rd(8'h00, v); check("R4 flag at wrap", v, 1);
      wr(8'h00, 16'h0001);

      // R7 power button
      wr(8'h02, 16'h0000);
      @(negedge clk); pwr_btn = 1'b1; @(negedge clk); pwr_btn = 1'b0;
      rd(8'h00, v); check("R7 button ignored when disabled", v, 0);
      @(negedge clk);
      check("R7 no sci when disabled", {31'h0, sci}, 0);
      wr(8'h02, 16'h0100);
      @(negedge clk); pwr_btn = 1'b1; @(negedge clk); pwr_btn = 1'b0;
      rd(8'h00, v); check("R7 button sets bit 8", v, 16'h0100);
      @(negedge clk);
      check("R5 sci from button", {31'h0, sci}, 1);
      wr(8'h00, 16'h0100);
      wr(8'h02, 16'h0000);

      // R6 soft off
      wr(8'h04, 16'h2000);
      check("R6 soft-off pulse", {31'h0, soft_off_req}, 1);
      @(negedge clk);
      check("R6 soft-off one cycle", {31'h0, soft_off_req}, 0);
      rd(8'h04, v); check("R6 control clear", v, 0);

      // R8 / R9 APM
      smi_allow = 1'b0;
      apm(1'b0, 8'hF1);
      check("R9 no smi when disallowed", {31'h0, smi_req}, 0);
      rd(8'h04, v); check("R8 F1 sets control bit 0", v, 1);
      smi_allow = 1'b1;
      apm(1'b0, 8'hF0);
      check("R9 smi pulse", {31'h0, smi_req}, 1);
      rd(8'h04, v); check("R8 F0 clears control bit 0", v, 0);
      @(negedge clk);
      check("R9 smi one cycle", {31'h0, smi_req}, 0);
      apm(1'b0, 8'h5A);
      rd(8'h04, v); check("R8 other value leaves control", v, 0);
      apm_sel = 1'b0; #1 check("R8 command stored", {24'h0, apm_rdata}, 8'h5A);
      @(negedge clk);
      apm(1'b1, 8'hC3);
      check("R9 status byte raises no smi", {31'h0, smi_req}, 0);
      apm_sel = 1'b1; #1 check("R9 status byte stored", {24'h0, apm_rdata}, 8'hC3);
      apm_sel = 1'b0; #1 check("R9 command kept", {24'h0, apm_rdata}, 8'h5A);

      finish_run();
   end
endmodule